// File: doc/BRIEF.md
# Pipelined 64-Input Ones Counter

The block takes a 64-bit word on every clock and reports how many of its bits are set, as a 7-bit count. The population count is built as a two-stage adder tree. The first registered stage splits the word into eight 8-bit groups and counts each group into a 4-bit partial result. The second registered stage adds the eight partials into the final count.

The result of a word therefore appears exactly two rising edges after the word is presented, and a new word may enter on every edge. A qualifier bit travels beside the data through both stages, so the consumer knows which output counts belong to real input words.

A build parameter removes the most significant input bit from the count. Counting only 63 inputs caps the result at 63. This lets synthesis prune one level of the final adder for applications that can afford to lose one end bit.

Top module: `pop_tree_pipe`

## Requirements
- R1: `count_o` equals the number of set bits in the `data_i` word that was sampled two rising edges of `clk_i` earlier.
- R2: The latency is exactly two clocks. In the clock cycle right after a word is sampled, `count_o` still shows the previous result. A different word may be accepted on every edge, with no gaps.
- R3: `valid_o` equals the `valid_i` that was sampled two rising edges earlier, aligned with the matching `count_o`.
- R4: While `rst_ni` is low, `count_o` is 0 and `valid_o` is 0, whatever the inputs are.
- R5: An all-ones word gives 64 when all bits are counted. It gives 63 when `DROP_END_BIT` is 1.
- R6: An all-zero word gives 0.
- R7: With `DROP_END_BIT` = 1, bit 63 (the MSB) of `data_i` has no effect on `count_o`. Only bits 62 down to 0 are counted.
- R8: Each first-stage partial count never exceeds the group width (8). The final count never exceeds the number of counted inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 64 | Word whose set bits are counted |
| valid_i | input | 1 | Qualifier for `data_i` |
| count_o | output | 7 | Registered count of set bits |
| valid_o | output | 1 | Qualifier for `count_o`, delayed two clocks |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One uses the default full 64-input count. The other sets `DROP_END_BIT` to 1.

Running the two copies in parallel lets every vector show the effect of the MSB. Words with bit 63 set give different expected counts on the two copies. This exposes a trim that drops the wrong end bit or is ignored altogether. The all-ones word reaches both ceilings: 64 on the full copy and 63 on the trimmed copy.

// File: rtl/pop_pkg.sv
package pop_pkg;
  // bits needed to hold a count of 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pop_stage1.sv
module pop_stage1 #(
  parameter int unsigned IN_W  = 64,
  parameter int unsigned GRP_W = 8,
  localparam int unsigned GRP_N  = IN_W / GRP_W,
  localparam int unsigned GRP_CW = pop_pkg::cnt_bits(GRP_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [IN_W-1:0]           data_i,
  output logic [GRP_N*GRP_CW-1:0]   part_o
);
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic [GRP_W-1:0]  grp_bits;
    logic [GRP_CW-1:0] grp_sum;
    logic [GRP_CW-1:0] grp_q;

    assign grp_bits = data_i[g*GRP_W +: GRP_W];

    always_comb begin
      grp_sum = '0;
      for (int b = 0; b < int'(GRP_W); b++)
        grp_sum = grp_sum + GRP_CW'(grp_bits[b]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_q <= '0;
      else         grp_q <= grp_sum;
    end

    assign part_o[g*GRP_CW +: GRP_CW] = grp_q;

    // R8
    part_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_q <= GRP_CW'(GRP_W));
  end
endmodule

// File: rtl/pop_stage2.sv
module pop_stage2 #(
  parameter int unsigned GRP_N  = 8,
  parameter int unsigned GRP_CW = 4,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned MAX_CNT = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [GRP_N*GRP_CW-1:0] part_i,
  output logic [CNT_W-1:0]        sum_o
);
  logic [CNT_W-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < int'(GRP_N); g++)
      sum_d = sum_d + CNT_W'(part_i[g*GRP_CW +: GRP_CW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_d;
  end

  // R8
  sum_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/pop_tree_pipe.sv
module pop_tree_pipe #(
  parameter int unsigned IN_W         = 64,
  parameter int unsigned GRP_W        = 8,
  parameter bit          DROP_END_BIT = 1'b0,
  localparam int unsigned GRP_N   = IN_W / GRP_W,
  localparam int unsigned GRP_CW  = pop_pkg::cnt_bits(GRP_W),
  localparam int unsigned CNT_W   = pop_pkg::cnt_bits(IN_W),
  localparam int unsigned MAX_CNT = DROP_END_BIT ? IN_W - 1 : IN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  logic [IN_W-1:0]         data_eff;
  logic [GRP_N*GRP_CW-1:0] part;
  logic [1:0]              vld_q;

  if (DROP_END_BIT) begin : g_trim
    assign data_eff = {1'b0, data_i[IN_W-2:0]};
  end else begin : g_full
    assign data_eff = data_i;
  end

  pop_stage1 #(.IN_W(IN_W), .GRP_W(GRP_W)) u_stage1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_eff),
    .part_o (part)
  );

  pop_stage2 #(.GRP_N(GRP_N), .GRP_CW(GRP_CW), .CNT_W(CNT_W),
               .MAX_CNT(MAX_CNT)) u_stage2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .part_i (part),
    .sum_o  (count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[0], valid_i};
  end
  assign valid_o = vld_q[1];

  // cycles since reset, saturating at 2; bounds the $past window
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R1
  count_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |=> count_o == CNT_W'($countones($past(data_eff, 2))));

  // R3
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |=> valid_o == $past(valid_i, 2));

  // R4
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && !valid_o));

  // R7
  if (DROP_END_BIT) begin : g_trim_chk
    trim_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CNT_W'(IN_W - 1));
  end
endmodule

// File: tb/pop_tree_pipe_tb.sv
module pop_tree_pipe_tb;
  localparam int unsigned IN_W  = 64;
  localparam int unsigned CNT_W = 7;
  localparam int unsigned N_TBL = 10;
  localparam int unsigned N_RND = 200;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [IN_W-1:0] data = '0;
  logic            valid = 1'b0;
  logic [CNT_W-1:0] cnt_full, cnt_trim;
  logic            vo_full, vo_trim;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pop_tree_pipe #(.IN_W(IN_W), .GRP_W(8), .DROP_END_BIT(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .valid_i(valid),
    .count_o(cnt_full), .valid_o(vo_full));

  pop_tree_pipe #(.IN_W(IN_W), .GRP_W(8), .DROP_END_BIT(1'b1)) u_dut_trim (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .valid_i(valid),
    .count_o(cnt_trim), .valid_o(vo_trim));

  // word, expected full count, expected trimmed count (R1 R5 R6 R7)
  localparam logic [IN_W-1:0] TBL_W [N_TBL] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
    64'hAAAA_AAAA_AAAA_AAAA, 64'h0F0F_0F0F_0F0F_0F0F,
    64'h0123_4567_89AB_CDEF, 64'hFF00_0000_0000_0000,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001};
  localparam int TBL_F [N_TBL] = '{0, 64, 1, 1, 32, 32, 32, 8, 63, 2};
  localparam int TBL_T [N_TBL] = '{0, 63, 0, 1, 31, 32, 32, 7, 63, 1};

  function automatic int ref_pop(input logic [IN_W-1:0] w, input bit trim);
    int s = 0;
    for (int b = 0; b < int'(IN_W); b++)
      if (!(trim && b == int'(IN_W) - 1)) s += int'(w[b]);
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [IN_W-1:0] rnd [N_RND];

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R4: reset holds outputs at zero despite busy inputs
    data = '1; valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 count full", int'(cnt_full), 0);
    chk("R4 count trim", int'(cnt_trim), 0);
    chk("R4 valid", int'(vo_full), 0);
    data = '0; valid = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 idle zero", int'(cnt_full), 0);

    // table walk, one word per clock (R1 R2 R5 R6 R7)
    for (int i = 0; i < int'(N_TBL) + 2; i++) begin
      if (i >= 2) begin
        chk($sformatf("R1 tbl%0d full", i-2), int'(cnt_full), TBL_F[i-2]);
        chk($sformatf("R7 tbl%0d trim", i-2), int'(cnt_trim), TBL_T[i-2]);
        chk($sformatf("R3 tbl%0d valid", i-2), int'(vo_full), 1);
      end
      if (i < int'(N_TBL)) begin data = TBL_W[i]; valid = 1'b1; end
      else begin data = '0; valid = 1'b0; end
      @(negedge clk);
    end
    chk("R3 valid drops", int'(vo_full), 0);

    // R2: exact latency of two edges
    data = 64'h0000_0000_0000_00FF; valid = 1'b1;
    @(negedge clk);
    data = '0; valid = 1'b0;
    chk("R2 one edge old", int'(cnt_full), 0);
    chk("R3 one edge old", int'(vo_full), 0);
    @(negedge clk);
    chk("R2 two edges", int'(cnt_full), 8);
    chk("R3 two edges", int'(vo_full), 1);
    @(negedge clk);
    chk("R2 next zero", int'(cnt_full), 0);

    // R7: only MSB toggling leaves trimmed count unchanged
    data = 64'h8000_0000_0000_0000; @(negedge clk);
    data = 64'h0000_0000_0000_0000; @(negedge clk);
    chk("R7 msb only trim", int'(cnt_trim), 0);
    chk("R7 msb only full", int'(cnt_full), 1);
    @(negedge clk);
    chk("R7 msb cleared trim", int'(cnt_trim), 0);

    // R3: alternating qualifier
    for (int i = 0; i < 8; i++) begin
      if (i >= 2) chk("R3 alt valid", int'(vo_trim), (i - 2) % 2);
      valid = i[0];
      @(negedge clk);
    end
    valid = 1'b0;

    // random stream (R1 R7 R8)
    for (int i = 0; i < int'(N_RND); i++) rnd[i] = {$urandom, $urandom};
    for (int i = 0; i < int'(N_RND) + 2; i++) begin
      if (i >= 2) begin
        chk("R1 rnd full", int'(cnt_full), ref_pop(rnd[i-2], 1'b0));
        chk("R7 rnd trim", int'(cnt_trim), ref_pop(rnd[i-2], 1'b1));
      end
      data = (i < int'(N_RND)) ? rnd[i] : '0;
      @(negedge clk);
    end

    // R4: async reset mid-stream clears at once
    data = '1; valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 full ceiling", int'(cnt_full), 64);
    chk("R5 trim ceiling", int'(cnt_trim), 63);
    #3 rst_ni = 1'b0;
    #2;
    chk("R4 async count", int'(cnt_full), 0);
    chk("R4 async valid", int'(vo_trim), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule